// File: doc/BRIEF.md
# Edge-Counting Serial Output Shifter

This block is the output side of a converter's three-wire read port. An external master supplies a serial clock. The block counts that clock's edges and drives a 16-bit frame on a data pin that can be three-stated. Each frame holds four leading zeros and then a 12-bit result, most significant bit first. The result comes from a parallel input and is captured on a load strobe. The load is only taken while a conversion-start pulse is holding the frame counter in its reset state.

Both the serial clock and the active-low conversion-start input are sampled by a faster system clock through two-flop synchronisers. Edges are detected in the system-clock domain. The data value and the output enable are brought out as separate signals, so the pad driver is built outside the block.

The master normally clocks exactly 16 falling edges and then leaves the clock low, and the pin is then released. If the master clocks further edges, the frame restarts and the pin stays driven. A conversion-start falling edge seen while the clock is high does not resynchronise the counter. Instead it raises a sticky error flag.

Top module: `sdo_frame_shifter`

## Requirements
- R1: `sclk_i` and `cnv_n_i` each pass through a two-stage synchroniser followed by an edge-detect register. A change driven just after a system-clock edge takes effect on the outputs three system-clock edges later.
- R2: From the armed state, the first rising serial-clock edge starts a frame. `sdo_oe_o` goes high and frame position 0, a zero, is driven.
- R3: Each falling serial-clock edge inside a frame advances the position by one. Positions 0 to 3 carry 0, and position p for p from 4 to 15 carries result bit 15-p. The frame is therefore 4 zeros followed by result bits 11 down to 0.
- R4: Result bit 0 is presented after the 15th falling edge and is held until the 16th. At the 16th falling edge `sdo_oe_o` drops low, unless persistent drive is set.
- R5: Rising edges inside a frame do not change the driven bit. Falling edges while armed are ignored.
- R6: A rising edge after a completed frame restarts the frame at position 0 from the held result and sets persistent drive. While persistent drive is set, `sdo_oe_o` stays high through and after the end of frame, and result bit 0 stays driven, until the next accepted conversion-start.
- R7: A conversion-start falling edge (`cnv_n_i` high to low) is accepted when the synchronised serial clock is low. It returns the block to the armed state at position 0, with `sdo_oe_o` low and persistent drive cleared.
- R8: A conversion-start falling edge while the synchronised serial clock is high leaves the frame unchanged and sets `desync_o`. The flag stays high until `rst_ni`.
- R9: `result_i` is captured when `load_i` is high, the synchronised conversion-start is low and the block is armed. A load at any other time is ignored.
- R10: After reset, `sdo_oe_o`, `sdo_o` and `desync_o` are 0, the held result is 0, and the block is armed.
- R11: `sdo_o` is 0 whenever `sdo_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| cnv_n_i | input | 1 | Conversion start, active low, asynchronous |
| load_i | input | 1 | Capture strobe for the result |
| result_i | input | 12 | Parallel result to be shifted out |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Output enable for the data pad |
| desync_o | output | 1 | Sticky flag: conversion start seen with the clock high |

## Verification
Every serial-clock or conversion-start change reaches the outputs exactly three system clocks after it is driven. A load strobe lands one system clock after it is driven. The bench keeps a behavioural reference with the same three-sample input delay and compares enable, data and the error flag against it at every falling system-clock edge. The directed checks hold each serial-clock level for four system clocks before sampling, so every bit read is past its settling cycle. One check samples both the second and the third cycle after a serial-clock rise, to pin the latency itself.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  localparam int FRAME_LEN  = 16;
  localparam int RES_W      = 12;
  localparam int LEAD_ZEROS = FRAME_LEN - RES_W;
  localparam int POS_W      = $clog2(FRAME_LEN);
  localparam int SYNC_STG   = 2;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DONE  = 2'd2
  } frame_st_e;
endpackage

// File: rtl/sfs_sync.sv
module sfs_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sfs_edge.sv
module sfs_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/sfs_frame_ctrl.sv
module sfs_frame_ctrl
  import sfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_lvl_i,
  input  logic             sclk_rise_i,
  input  logic             sclk_fall_i,
  input  logic             cnv_lvl_i,
  input  logic             cnv_fall_i,
  input  logic             load_i,
  output frame_st_e        state_o,
  output logic [POS_W-1:0] pos_o,
  output logic             persist_o,
  output logic             desync_o,
  output logic             cnv_ok_o,
  output logic             load_en_o
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_LEN - 1);

  frame_st_e        st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic             persist_q, persist_d;
  logic             desync_q;

  // resync only when the serial clock is low at the start edge
  assign cnv_ok_o  = cnv_fall_i & ~sclk_lvl_i;
  assign load_en_o = load_i & ~cnv_lvl_i & (st_q == ST_ARMED);

  always_comb begin
    st_d      = st_q;
    pos_d     = pos_q;
    persist_d = persist_q;
    if (cnv_ok_o) begin
      st_d      = ST_ARMED;
      pos_d     = '0;
      persist_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_ARMED: if (sclk_rise_i) begin
          st_d  = ST_SHIFT;
          pos_d = '0;
        end
        ST_SHIFT: if (sclk_fall_i) begin
          if (pos_q == LAST_POS) st_d = ST_DONE;
          else                   pos_d = pos_q + 1'b1;
        end
        ST_DONE: if (sclk_rise_i) begin
          st_d      = ST_SHIFT;
          pos_d     = '0;
          persist_d = 1'b1;
        end
        default: st_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_ARMED;
      pos_q     <= '0;
      persist_q <= 1'b0;
      desync_q  <= 1'b0;
    end else begin
      st_q      <= st_d;
      pos_q     <= pos_d;
      persist_q <= persist_d;
      if (cnv_fall_i && sclk_lvl_i) desync_q <= 1'b1;
    end
  end

  assign state_o   = st_q;
  assign pos_o     = pos_q;
  assign persist_o = persist_q;
  assign desync_o  = desync_q;
endmodule

// File: rtl/sfs_out_sel.sv
module sfs_out_sel
  import sfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_en_i,
  input  logic [RES_W-1:0] result_i,
  input  frame_st_e        state_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             persist_i,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  logic [RES_W-1:0]     res_q;
  logic [FRAME_LEN-1:0] frame_vec;
  logic                 bit_sel;
  logic                 oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        res_q <= '0;
    else if (load_en_i) res_q <= result_i;
  end

  assign frame_vec = {{LEAD_ZEROS{1'b0}}, res_q};

  always_comb begin
    bit_sel = 1'b0;
    oe      = 1'b0;
    unique case (state_i)
      ST_SHIFT: begin
        oe      = 1'b1;
        bit_sel = frame_vec[POS_W'(FRAME_LEN - 1) - pos_i];
      end
      ST_DONE: begin
        oe      = persist_i;
        bit_sel = res_q[0];
      end
      default: ;
    endcase
  end

  assign sdo_oe_o = oe;
  assign sdo_o    = oe & bit_sel;
endmodule

// File: rtl/sdo_frame_shifter.sv
module sdo_frame_shifter
  import sfs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_i,
  input  logic             cnv_n_i,
  input  logic             load_i,
  input  logic [RES_W-1:0] result_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  output logic             desync_o
);
  logic [1:0]       raw_lvl, sync_lvl, lvl_rise, lvl_fall;
  logic             sclk_rise, sclk_fall, cnv_fall, cnv_ok, load_en, persist;
  frame_st_e        state;
  logic [POS_W-1:0] pos;

  assign raw_lvl = {cnv_n_i, sclk_i};

  sfs_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_lvl), .q_o(sync_lvl)
  );

  sfs_edge #(.W(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_lvl),
    .rise_o(lvl_rise), .fall_o(lvl_fall)
  );

  assign sclk_rise = lvl_rise[0];
  assign sclk_fall = lvl_fall[0];
  assign cnv_fall  = lvl_fall[1];

  sfs_frame_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .sclk_lvl_i(sync_lvl[0]), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cnv_lvl_i(sync_lvl[1]), .cnv_fall_i(cnv_fall), .load_i(load_i),
    .state_o(state), .pos_o(pos), .persist_o(persist), .desync_o(desync_o),
    .cnv_ok_o(cnv_ok), .load_en_o(load_en)
  );

  sfs_out_sel u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_en_i(load_en), .result_i(result_i),
    .state_i(state), .pos_i(pos), .persist_i(persist),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker
  import sfs_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sdo_o,
  input logic             sdo_oe_o,
  input logic             desync_o,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             cnv_ok,
  input frame_st_e        state,
  input logic [POS_W-1:0] pos
);
  a_r2_oe_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sdo_oe_o) |-> $past(sclk_rise));

  a_r3_lead_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_SHIFT && pos < POS_W'(LEAD_ZEROS)) |-> !sdo_o);

  a_r3_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall && !cnv_ok && state == ST_SHIFT && pos != POS_W'(FRAME_LEN - 1))
      |=> (pos == $past(pos) + 1'b1));

  a_r7_cnv_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnv_ok |=> !sdo_oe_o);

  a_r8_desync_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    desync_o |=> desync_o);

  a_r11_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdo_oe_o |-> !sdo_o);
endmodule

bind sdo_frame_shifter sfs_checker u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .desync_o(desync_o), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
  .cnv_ok(cnv_ok), .state(state), .pos(pos)
);

// File: tb/sim_sdo_frame_shifter.sv
module sim_sdo_frame_shifter;
  localparam int CLK_PER = 10;
  localparam int SETTLE  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cnv_n = 1'b1, load = 1'b0;
  logic [11:0] result = '0;
  logic sdo, sdo_oe, desync;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  sdo_frame_shifter u0 (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cnv_n_i(cnv_n),
    .load_i(load), .result_i(result),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .desync_o(desync)
  );

  // behavioural reference: 3-sample delay on clock and conversion start
  int m_s1s, m_s2s, m_qs, m_s1c, m_s2c, m_qc;
  int m_st, m_pos, m_persist, m_desync, m_res;
  bit m_oe, m_sdo;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1s = 0; m_s2s = 0; m_qs = 0; m_s1c = 0; m_s2c = 0; m_qc = 0;
      m_st = 0; m_pos = 0; m_persist = 0; m_desync = 0; m_res = 0;
    end else begin
      bit rs, fs, fc, ok;
      rs = (m_s2s == 1) && (m_qs == 0);
      fs = (m_s2s == 0) && (m_qs == 1);
      fc = (m_s2c == 0) && (m_qc == 1);
      ok = fc && (m_s2s == 0);
      if (load && m_s2c == 0 && m_st == 0) m_res = int'(result);
      if (fc && m_s2s == 1) m_desync = 1;
      if (ok) begin
        m_st = 0; m_pos = 0; m_persist = 0;
      end else if (m_st == 0 && rs) begin
        m_st = 1; m_pos = 0;
      end else if (m_st == 1 && fs) begin
        if (m_pos == 15) m_st = 2; else m_pos++;
      end else if (m_st == 2 && rs) begin
        m_st = 1; m_pos = 0; m_persist = 1;
      end
      m_qs = m_s2s; m_s2s = m_s1s; m_s1s = int'(sclk);
      m_qc = m_s2c; m_s2c = m_s1c; m_s1c = int'(cnv_n);
    end
  end

  always_comb begin
    m_oe  = (m_st == 1) || (m_st == 2 && m_persist == 1);
    m_sdo = 1'b0;
    if (m_st == 1 && m_pos >= 4) m_sdo = 1'((m_res >> (15 - m_pos)) & 1);
    else if (m_st == 2 && m_persist == 1) m_sdo = 1'(m_res & 1);
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R2 model oe", int'(sdo_oe), int'(m_oe));
    check("R3 model sdo", int'(sdo), int'(m_sdo));
    check("R8 model desync", int'(desync), m_desync);
  end

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
      finish_run();
    end
  end

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic step(input logic v);
    sclk = v;
    wait_n(SETTLE);
  endtask

  task automatic cnv_pulse(input bit do_load, input logic [11:0] v);
    cnv_n = 1'b0;
    wait_n(3);
    if (do_load) begin
      result = v; load = 1'b1;
      wait_n(1);
      load = 1'b0;
    end
    wait_n(2);
    cnv_n = 1'b1;
    wait_n(SETTLE);
  endtask

  task automatic read_frame(output logic [15:0] w);
    step(1'b1);
    w[15] = sdo;
    for (int i = 1; i < 16; i++) begin
      step(1'b0);
      w[15-i] = sdo;
      step(1'b1);
    end
    step(1'b0);
  endtask

  initial begin
    logic [15:0] w;
    wait_n(3);
    // R10 reset state
    check("R10 oe", int'(sdo_oe), 0);
    check("R10 sdo", int'(sdo), 0);
    check("R10 desync", int'(desync), 0);
    rst_n = 1'b1;
    wait_n(4);

    cnv_pulse(1, 12'hA5C);
    // R1 latency: output changes on the third edge after the drive
    sclk = 1'b1;
    wait_n(2);
    check("R1 oe before 3rd edge", int'(sdo_oe), 0);
    wait_n(1);
    check("R1 oe at 3rd edge", int'(sdo_oe), 1);
    check("R2 first bit zero", int'(sdo), 0);
    wait_n(1);
    w[15] = sdo;
    for (int i = 1; i < 16; i++) begin
      step(1'b0); w[15-i] = sdo; step(1'b1);
    end
    check("R5 bit0 held before 16th fall", int'(sdo), 0);
    step(1'b0);
    check("R3 frame 0xA5C", int'(w), 16'h0A5C);
    check("R4 released after 16th fall", int'(sdo_oe), 0);
    check("R11 data low when released", int'(sdo), 0);

    // R9 load ignored when not armed (frame done) and when cnv high
    result = 12'h111; load = 1'b1; wait_n(2); load = 1'b0;
    cnv_pulse(0, 12'h000);
    result = 12'h222; load = 1'b1; wait_n(2); load = 1'b0;
    read_frame(w);
    check("R9 stale loads ignored", int'(w), 16'h0A5C);

    // R6 extra clock restarts with persistent drive
    cnv_pulse(1, 12'h3F1);
    read_frame(w);
    check("R3 frame 0x3F1", int'(w), 16'h03F1);
    check("R4 released", int'(sdo_oe), 0);
    step(1'b1);
    check("R6 restart drives", int'(sdo_oe), 1);
    check("R6 restart position 0", int'(sdo), 0);
    for (int i = 1; i < 16; i++) begin
      step(1'b0); step(1'b1);
    end
    step(1'b0);
    wait_n(10);
    check("R6 pin stays driven", int'(sdo_oe), 1);
    check("R6 holds bit0", int'(sdo), 1);

    // R7 accepted conversion start clears persistent drive
    cnv_pulse(1, 12'h801);
    check("R7 oe low after resync", int'(sdo_oe), 0);
    read_frame(w);
    check("R7 fresh frame", int'(w), 16'h0801);
    check("R7 persist cleared", int'(sdo_oe), 0);

    // R8 conversion start with clock high: flag, frame unaffected
    cnv_pulse(1, 12'hC35);
    step(1'b1);
    for (int i = 0; i < 3; i++) begin
      step(1'b0); step(1'b1);
    end
    cnv_n = 1'b0; wait_n(SETTLE);
    check("R8 desync set", int'(desync), 1);
    cnv_n = 1'b1; wait_n(SETTLE);
    step(1'b0);
    check("R8 frame continues DB11", int'(sdo), 1);
    check("R8 still driving", int'(sdo_oe), 1);
    for (int i = 0; i < 12; i++) begin
      step(1'b1); step(1'b0);
    end
    check("R8 frame ended", int'(sdo_oe), 0);
    cnv_pulse(0, 12'h000);
    check("R8 flag sticky", int'(desync), 1);

    finish_run();
  end
endmodule